// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block is a small data cache for a 32-bit processor: 32 lines of 32 bytes, arranged as 16 sets with two ways each. The processor presents a word request (address, direction, byte mask, store data) and holds it until the cache raises `cpu_ready`. A read that hits completes in the same cycle it is presented. Both ways of the indexed set are read while their tags are compared, and the word from the matching way is selected. A read miss stalls the processor. The cache fetches the whole line from the lower level one word at a time, installs it, and then completes the read as a hit.

Stores are written through. A store takes a compare cycle first and an update cycle second, so no line is touched before a hit is known. A store hit merges the enabled bytes into the cached word. A store miss leaves the cache untouched. In both cases the store is placed in a small write buffer, which drains to the lower level while the processor moves on. A read miss starts its line fetch only after that buffer is empty, so a fetched line always includes the earlier stores.

Top module: `cache2w`

## Requirements
- R1: After reset every line is invalid and no lower-level request is outstanding. `mem_req` is 0, and the first read of any address misses.
- R2: A read that hits raises `cpu_ready` in the first cycle of the request and returns the stored word from the way whose tag matches.
- R3: A read miss fetches the line as 8 word reads at byte addresses line_base+0, +4, ..., +28, in that order. It then returns the requested word. Any word of that line then hits.
- R4: A store takes exactly two cycles (compare, then update) when the write buffer has room. `cpu_ready` is high in the second cycle.
- R5: A store hit updates only the bytes of the addressed word whose `cpu_be` bit is set. Bit i enables bits 8i+7..8i.
- R6: A store miss does not allocate a line. A later read of that address misses and returns the stored data.
- R7: Every store reaches the lower level once, in issue order, as a write with its word address, data and byte mask. The address is held stable until `mem_ack`.
- R8: When the write buffer is full, a store waits in its update cycle with `cpu_ready` low until an entry drains.
- R9: A read miss issues no lower-level read while any buffered store is still pending.
- R10: The victim is an invalid way if one exists, otherwise the way of the set used least recently.
- R11: Address bits [8:5] select the set and only bits [31:9] are compared. Two lines with the same index and different tags reside together, and at most one way hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Store byte mask |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` on a load |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Lower-level word request |
| mem_write | output | 1 | 1 = buffered store, 0 = line fetch read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte mask of the write |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume two things about the processor. It holds address, direction, mask and data unchanged from the start of a request until the edge where `cpu_ready` is seen. It also issues one request at a time. The lower level is assumed to answer each request with a single-cycle `mem_ack`. The bench drives each request from a task that keeps every field fixed until the accepting edge. Its memory model pulses the acknowledge for one cycle after a programmable wait, which lets it stretch the drain time to fill the buffer.

// File: rtl/cache2w.sv
module cache2w #(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 8,
  parameter int WB_DEPTH   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  input  logic        cpu_write,
  input  logic [31:0] cpu_addr,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        mem_req,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFS_W = $clog2(LINE_WORDS);
  localparam int TAG_W = 32 - IDX_W - OFS_W - 2;
  localparam int WBP_W = $clog2(WB_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_FILL} state_t;
  state_t st;

  logic [31:0]      data_q [2][SETS*LINE_WORDS];
  logic [TAG_W-1:0] tag_q  [2][SETS];
  logic [SETS-1:0]  valid_q [2];
  logic [SETS-1:0]  mru_q;

  wire [TAG_W-1:0] a_tag = cpu_addr[31 -: TAG_W];
  wire [IDX_W-1:0] a_idx = cpu_addr[2+OFS_W +: IDX_W];
  wire [OFS_W-1:0] a_ofs = cpu_addr[2 +: OFS_W];
  wire             unused_lsbs = ^cpu_addr[1:0];

  logic [1:0] hit;
  always_comb
    for (int w = 0; w < 2; w++)
      hit[w] = valid_q[w][a_idx] && (tag_q[w][a_idx] == a_tag);

  wire [31:0] word0 = data_q[0][{a_idx, a_ofs}];
  wire [31:0] word1 = data_q[1][{a_idx, a_ofs}];
  assign cpu_rdata = hit[1] ? word1 : word0;

  wire victim = !valid_q[0][a_idx] ? 1'b0 :
                !valid_q[1][a_idx] ? 1'b1 : !mru_q[a_idx];

  logic             st_hit_q, st_way_q, v_way_q;
  logic [OFS_W-1:0] cnt_q;

  logic [29:0]      wb_addr [WB_DEPTH];
  logic [31:0]      wb_data [WB_DEPTH];
  logic [3:0]       wb_be   [WB_DEPTH];
  logic [WBP_W-1:0] wb_head, wb_tail;
  logic [WBP_W:0]   wb_count;
  wire wb_empty = (wb_count == '0);
  wire wb_full  = (wb_count == (WBP_W+1)'(WB_DEPTH));

  wire fill_mode = (st == S_FILL);
  wire wb_push   = (st == S_STORE) && !wb_full;
  wire wb_pop    = !fill_mode && !wb_empty && mem_ack;
  wire fill_last = fill_mode && mem_ack && (cnt_q == OFS_W'(LINE_WORDS-1));

  assign cpu_ready = (st == S_IDLE && cpu_valid && !cpu_write && |hit) || wb_push;
  assign mem_req   = fill_mode || !wb_empty;
  assign mem_write = !fill_mode;
  assign mem_addr  = fill_mode ? {a_tag, a_idx, cnt_q, 2'b00} : {wb_addr[wb_head], 2'b00};
  assign mem_be    = fill_mode ? 4'hF : wb_be[wb_head];
  assign mem_wdata = wb_data[wb_head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      valid_q  <= '{default: '0};
      mru_q    <= '0;
      cnt_q    <= '0;
      st_hit_q <= 1'b0;
      st_way_q <= 1'b0;
      v_way_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cpu_valid) begin
          if (cpu_write) begin
            st       <= S_STORE;
            st_hit_q <= |hit;
            st_way_q <= hit[1];
          end else if (|hit) begin
            mru_q[a_idx] <= hit[1];
          end else if (wb_empty) begin
            st                      <= S_FILL;
            v_way_q                 <= victim;
            cnt_q                   <= '0;
            valid_q[victim][a_idx]  <= 1'b0;
          end
        end
        S_STORE: if (!wb_full) begin
          st <= S_IDLE;
          if (st_hit_q) mru_q[a_idx] <= st_way_q;
        end
        default: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (fill_last) begin
            valid_q[v_way_q][a_idx] <= 1'b1;
            mru_q[a_idx]            <= v_way_q;
            st                      <= S_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wb_push && st_hit_q)
      for (int b = 0; b < 4; b++)
        if (cpu_be[b]) data_q[st_way_q][{a_idx, a_ofs}][8*b +: 8] <= cpu_wdata[8*b +: 8];
    if (fill_mode && mem_ack) data_q[v_way_q][{a_idx, cnt_q}] <= mem_rdata;
    if (fill_last) tag_q[v_way_q][a_idx] <= a_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_head  <= '0;
      wb_tail  <= '0;
      wb_count <= '0;
    end else begin
      if (wb_push) wb_tail <= wb_tail + 1'b1;
      if (wb_pop)  wb_head <= wb_head + 1'b1;
      wb_count <= wb_count + (WBP_W+1)'(wb_push) - (WBP_W+1)'(wb_pop);
    end
  end

  always_ff @(posedge clk)
    if (wb_push) begin
      wb_addr[wb_tail] <= cpu_addr[31:2];
      wb_data[wb_tail] <= cpu_wdata;
      wb_be[wb_tail]   <= cpu_be;
    end

  assert_single_way_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> $onehot0(hit));
  assert_fetch_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_write) |-> wb_empty);
  assert_buffer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= (WBP_W+1)'(WB_DEPTH));
  assert_request_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
  assert_store_compare_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && cpu_ready) |-> $past(cpu_valid && cpu_write && !cpu_ready));
endmodule

// File: tb/test_cache2w.sv
module test_cache2w;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_write, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;

  cache2w i_cache2w (.*);

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0, mem_lat = 1;
  bit done = 0;
  logic [31:0] ref_mem [int unsigned];
  logic [31:0] phy_mem [int unsigned];
  logic [31:0] exp_data [$];
  string       exp_tag  [$];
  logic [31:0] wq_addr [$], wq_data [$];
  logic [3:0]  wq_be [$];
  logic [31:0] fill_log [$];

  function automatic logic [31:0] init_val(input int unsigned w);
    return {w[15:0], ~w[15:0]} ^ 32'h5A00_00A5;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input string tag, output int cyc);
    @(negedge clk);
    cpu_valid = 1; cpu_write = 0; cpu_addr = a; cpu_be = 4'hF;
    exp_data.push_back(ref_mem.exists(a[31:2]) ? ref_mem[a[31:2]] : init_val(a[31:2]));
    exp_tag.push_back(tag);
    fill_log.delete();
    cyc = 0;
    forever begin #0.5; cyc++; if (cpu_ready) break; @(negedge clk); end
    @(posedge clk); #0.5; cpu_valid = 0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, output int cyc);
    logic [31:0] old;
    @(negedge clk);
    cpu_valid = 1; cpu_write = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    old = ref_mem.exists(a[31:2]) ? ref_mem[a[31:2]] : init_val(a[31:2]);
    ref_mem[a[31:2]] = merge(old, d, be);
    wq_addr.push_back({a[31:2], 2'b00}); wq_data.push_back(d); wq_be.push_back(be);
    cyc = 0;
    forever begin #0.5; cyc++; if (cpu_ready) break; @(negedge clk); end
    @(posedge clk); #0.5; cpu_valid = 0;
  endtask

  task automatic chk_fill(input logic [31:0] a, input string tag);
    logic [31:0] base = {a[31:5], 5'b0};
    chk(fill_log.size() == 8, tag, fill_log.size(), 8);
    for (int i = 0; i < fill_log.size() && i < 8; i++)
      chk(fill_log[i] == base + 4*i, tag, fill_log[i], base + 4*i);
  endtask

  // lower-level memory model
  initial begin
    int waitc = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (waitc >= mem_lat - 1) begin
          waitc = 0;
          mem_ack = 1;
          if (mem_write) begin
            if (wq_addr.size() == 0) chk(0, "R7 unexpected write", mem_addr, 0);
            else begin
              chk(mem_addr == wq_addr[0], "R7 write address", mem_addr, wq_addr[0]);
              chk(mem_wdata == wq_data[0], "R7 write data", mem_wdata, wq_data[0]);
              chk(mem_be == wq_be[0], "R7 write mask", {28'b0, mem_be}, {28'b0, wq_be[0]});
              void'(wq_addr.pop_front()); void'(wq_data.pop_front()); void'(wq_be.pop_front());
            end
            phy_mem[mem_addr[31:2]] = merge(phy_mem.exists(mem_addr[31:2]) ?
                phy_mem[mem_addr[31:2]] : init_val(mem_addr[31:2]), mem_wdata, mem_be);
          end else begin
            chk(wq_addr.size() == 0, "R9 fetch with stores pending", wq_addr.size(), 0);
            fill_log.push_back(mem_addr);
            mem_rdata = phy_mem.exists(mem_addr[31:2]) ? phy_mem[mem_addr[31:2]] : init_val(mem_addr[31:2]);
          end
        end else waitc++;
      end
    end
  end

  // read scoreboard monitor
  initial forever begin
    @(negedge clk); #1;
    if (cpu_valid && !cpu_write && cpu_ready) begin
      if (exp_data.size() == 0) chk(0, "unexpected read completion", cpu_rdata, 0);
      else begin
        chk(cpu_rdata == exp_data[0], exp_tag[0], cpu_rdata, exp_data[0]);
        void'(exp_data.pop_front()); void'(exp_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int c, mx;
    logic [31:0] A = 32'h0000_1024, B = 32'h0000_2024, C = 32'h0000_3024, D = 32'h0000_5040;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0, "R1 no request after reset", mem_req, 0);
    chk(cpu_ready == 0, "R1 idle ready", cpu_ready, 0);

    do_read(A, "R1 R3 miss data", c);
    chk(c > 1, "R1 first read misses", c, 2);
    chk_fill(A, "R3 line fetch order");
    do_read(A, "R2 hit data", c);
    chk(c == 1, "R2 hit latency", c, 1);
    do_read(A + 4, "R3 neighbour word", c);
    chk(c == 1, "R3 whole line installed", c, 1);

    do_read(B, "R11 second tag data", c);
    chk(c > 1, "R11 second tag misses", c, 2);
    do_read(A, "R11 first tag data", c);
    chk(c == 1, "R11 R10 both ways resident", c, 1);
    do_read(C, "R10 third tag data", c);
    chk(c > 1, "R10 third tag misses", c, 2);
    do_read(A, "R10 recent line kept", c);
    chk(c == 1, "R10 recently used survives", c, 1);
    do_read(B, "R10 evicted data", c);
    chk(c > 1, "R10 least recent evicted", c, 2);

    do_read(C, "R10 reload C", c);
    do_write(C, 32'hDEAD_BEEF, 4'b0101, c);
    chk(c == 2, "R4 store hit takes two cycles", c, 2);
    do_read(C, "R5 byte merge", c);
    chk(c == 1, "R5 line still hits", c, 1);

    do_write(D, 32'h1234_5678, 4'hF, c);
    chk(c == 2, "R4 store miss takes two cycles", c, 2);
    do_read(D, "R6 stored data after miss", c);
    chk(c > 1, "R6 store miss did not allocate", c, 2);
    chk_fill(D, "R6 fetch after store miss");

    mem_lat = 6; mx = 0;
    for (int i = 0; i < 6; i++) begin
      do_write(32'h0000_6000 + 4*i, 32'hA000_0000 + i, 4'hF, c);
      if (i < 3) chk(c == 2, "R4 store with room", c, 2);
      if (c > mx) mx = c;
    end
    chk(mx > 2, "R8 full buffer stalls store", mx, 3);
    do_read(32'h0000_6014, "R9 read after full buffer", c);
    mem_lat = 1;

    repeat (40) @(posedge clk);
    #0.5;
    chk(wq_addr.size() == 0, "R7 every store reached memory", wq_addr.size(), 0);
    chk(exp_data.size() == 0, "R2 every read completed", exp_data.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule